// File: doc/BRIEF.md
# Configurable-Polarity Set/Reset Storage Element

This block models a legacy set/reset storage bit inside a fully synchronous design. It has one set input and one clear input, and it drives a true output and a complementary output. A fast system clock samples the inputs on every rising edge, so the block behaves like an asynchronous latch whose timing is fixed and repeatable. One parameter picks the active level of the two inputs. A separate parameter picks the active level of the outputs. The inputs are active-low by default and the outputs are normal by default.

A mode parameter picks one of two behaviours. Level mode is the main one: set forces a 1, clear forces a 0, and clear wins when both are active. Toggle mode inverts the stored bit once each time both inputs become active together. In toggle mode a lone set or a lone clear still forces the bit to 1 or 0.

Top module: `pol_srff`

## Requirements
- R1: While `rst` is high at a rising edge, the stored state becomes 0. After that edge `q` shows 0 (or 1 when OUT_INVERT=1) and `q_n` shows the inverse.
- R2: An active set with an inactive clear makes the stored state 1 after the next rising edge. The state stays 1 for as long as that input pattern is held.
- R3: An active clear with an inactive set makes the stored state 0 after the next rising edge.
- R4: In level mode (MODE_LEVEL), set and clear active together make the stored state 0, as if only clear were active.
- R5: With neither input active, the stored state keeps its value indefinitely.
- R6: With IN_ACTIVE_LOW=1 (the default), an input is active when it is 0, and a 1 on it has no effect. With IN_ACTIVE_LOW=0, an input is active when it is 1, and a 0 on it has no effect.
- R7: With OUT_INVERT=0 (the default), `q` equals the stored state. With OUT_INVERT=1, `q` equals the inverse of the stored state.
- R8: `q_n` is always the exact inverse of `q`, and both outputs change on the same clock edge.
- R9: In toggle mode (MODE_TOGGLE), the stored state inverts on the first edge at which set and clear are both active. It then holds while both stay active.
- R10: In toggle mode, a lone active set still forces the state to 1, and a lone active clear still forces it to 0.
- R11: The outputs reflect the inputs sampled at a rising edge immediately after that edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| set_in | input | 1 | Set request, active level chosen by IN_ACTIVE_LOW |
| clr_in | input | 1 | Clear request, active level chosen by IN_ACTIVE_LOW |
| q | output | 1 | True output, polarity chosen by OUT_INVERT |
| q_n | output | 1 | Complementary output, always the inverse of q |

## Verification
A wrong stored bit shows up on `q` and `q_n` immediately after the edge at which the bad value is written. A missed set, a clear that fails to win, or a toggle that is missed or repeated therefore appears one cycle after the input pattern that caused it. Because a held state persists until the next set or clear, one wrong update stays visible on the outputs over the following hold cycles. Comparing every cycle against a reference model catches it within one cycle.

// File: rtl/srff_pkg.sv
package srff_pkg;
  typedef enum logic {
    MODE_LEVEL  = 1'b0,
    MODE_TOGGLE = 1'b1
  } srff_mode_e;
endpackage

// File: rtl/srff_in_cond.sv
// Maps raw input pins to active-high request strobes.
module srff_in_cond #(
  parameter bit IN_ACTIVE_LOW = 1'b1
) (
  input  logic set_raw,
  input  logic clr_raw,
  output logic set_act,
  output logic clr_act
);
  generate
    if (IN_ACTIVE_LOW) begin : g_low
      assign set_act = ~set_raw;
      assign clr_act = ~clr_raw;
    end else begin : g_high
      assign set_act = set_raw;
      assign clr_act = clr_raw;
    end
  endgenerate
endmodule

// File: rtl/srff_core.sv
// State register plus next-state logic for the chosen mode.
module srff_core
  import srff_pkg::*;
#(
  parameter srff_mode_e MODE = MODE_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic set_act,
  input  logic clr_act,
  output logic st,
  output logic st_nxt
);
  logic both;
  assign both = set_act & clr_act;

  generate
    if (MODE == MODE_TOGGLE) begin : g_toggle
      logic both_d;
      always_ff @(posedge clk) begin
        if (rst) both_d <= 1'b0;
        else     both_d <= both;
      end
      always_comb begin
        if (both && !both_d)  st_nxt = ~st;
        else if (both)        st_nxt = st;
        else if (set_act)     st_nxt = 1'b1;
        else if (clr_act)     st_nxt = 1'b0;
        else                  st_nxt = st;
      end
      // R9: first cycle of joint activity flips the bit
      a_r9_toggle_once: assert property (@(posedge clk) disable iff (rst)
        (both && !both_d) |=> (st != $past(st)));
      // R9: sustained joint activity holds the bit
      a_r9_toggle_hold: assert property (@(posedge clk) disable iff (rst)
        (both && both_d) |=> $stable(st));
    end else begin : g_level
      always_comb begin
        if (clr_act)      st_nxt = 1'b0;
        else if (set_act) st_nxt = 1'b1;
        else              st_nxt = st;
      end
      // R4: clear dominates
      a_r4_clear_wins: assert property (@(posedge clk) disable iff (rst)
        both |=> !st);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) st <= 1'b0;
    else     st <= st_nxt;
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> !st);
  a_r2_set_forces: assert property (@(posedge clk) disable iff (rst)
    (set_act && !clr_act) |=> st);
  a_r3_clear_forces: assert property (@(posedge clk) disable iff (rst)
    (clr_act && !set_act) |=> !st);
  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!set_act && !clr_act) |=> $stable(st));
endmodule

// File: rtl/srff_out_stage.sv
// Registered true/complement outputs with selectable polarity.
module srff_out_stage #(
  parameter bit OUT_INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic st_nxt,
  output logic q,
  output logic q_n
);
  logic pol_val;
  generate
    if (OUT_INVERT) begin : g_inv
      assign pol_val = ~st_nxt;
    end else begin : g_norm
      assign pol_val = st_nxt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= OUT_INVERT;
      q_n <= ~OUT_INVERT;
    end else begin
      q   <= pol_val;
      q_n <= ~pol_val;
    end
  end

  a_r8_complement: assert property (@(posedge clk) disable iff (rst)
    q_n == ~q);
endmodule

// File: rtl/pol_srff.sv
module pol_srff
  import srff_pkg::*;
#(
  parameter bit         IN_ACTIVE_LOW = 1'b1,
  parameter bit         OUT_INVERT    = 1'b0,
  parameter srff_mode_e MODE          = MODE_LEVEL
) (
  input  logic clk,
  input  logic rst,
  input  logic set_in,
  input  logic clr_in,
  output logic q,
  output logic q_n
);
  logic set_act, clr_act, st, st_nxt;

  srff_in_cond #(.IN_ACTIVE_LOW(IN_ACTIVE_LOW)) u_in (
    .set_raw(set_in), .clr_raw(clr_in),
    .set_act(set_act), .clr_act(clr_act)
  );

  srff_core #(.MODE(MODE)) u_core (
    .clk(clk), .rst(rst),
    .set_act(set_act), .clr_act(clr_act),
    .st(st), .st_nxt(st_nxt)
  );

  srff_out_stage #(.OUT_INVERT(OUT_INVERT)) u_out (
    .clk(clk), .rst(rst), .st_nxt(st_nxt),
    .q(q), .q_n(q_n)
  );

  // R7: output register tracks the state register through the polarity choice
  a_r7_polarity: assert property (@(posedge clk) disable iff (rst)
    q == (st ^ OUT_INVERT));
endmodule

// File: tb/pol_srff_bench.sv
module pol_srff_bench;
  import srff_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_set, a_clr, b_set, b_clr;
  logic a_q, a_qn, b_q, b_qn;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  // model state
  bit st_a, st_b, prev_both_b;

  always #2 clk = ~clk;  // 250 MHz

  // default: active-low inputs, normal outputs, level mode
  pol_srff u_pol_srff (
    .clk(clk), .rst(rst), .set_in(a_set), .clr_in(a_clr),
    .q(a_q), .q_n(a_qn)
  );

  // active-high inputs, inverted outputs, toggle mode
  pol_srff #(.IN_ACTIVE_LOW(1'b0), .OUT_INVERT(1'b1), .MODE(MODE_TOGGLE)) u_pol_srff_tg (
    .clk(clk), .rst(rst), .set_in(b_set), .clr_in(b_clr),
    .q(b_q), .q_n(b_qn)
  );

  function automatic bit lvl_next(bit st, bit s, bit r);
    if (r) return 1'b0;
    if (s) return 1'b1;
    return st;
  endfunction

  function automatic bit tgl_next(bit st, bit s, bit r, bit pb);
    if (s && r && !pb) return ~st;
    if (s && r)        return st;
    if (s)             return 1'b1;
    if (r)             return 1'b0;
    return st;
  endfunction

  task automatic check(string tag, string who, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, who, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check(tag, "A.q", a_q, st_a);
    check("R8", "A.q_n", a_qn, ~st_a);
    check(tag, "B.q", b_q, ~st_b);
    check("R8", "B.q_n", b_qn, st_b);
  endtask

  // drive logical (active-high) requests, then check after the edge (R11)
  task automatic step(bit s, bit r, string tag);
    a_set = ~s; a_clr = ~r;
    b_set = s;  b_clr = r;
    @(posedge clk);
    @(negedge clk);
    st_a = lvl_next(st_a, s, r);
    st_b = tgl_next(st_b, s, r, prev_both_b);
    prev_both_b = s & r;
    check_outs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    a_set = 1'b1; a_clr = 1'b1; b_set = 1'b0; b_clr = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    st_a = 1'b0; st_b = 1'b0; prev_both_b = 1'b0;
    check_outs("R1");
    rst = 1'b0;

    step(1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R3");
    step(1'b1, 1'b0, "R11");
    step(1'b1, 1'b1, "R4 R9");
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b1, "R9");
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b1, "R10");
    step(1'b1, 1'b0, "R10");
    step(1'b1, 1'b1, "R4");
    step(1'b0, 1'b0, "R7");

    // reset from a set state
    step(1'b1, 1'b0, "R2");
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    st_a = 1'b0; st_b = 1'b0; prev_both_b = 1'b0;
    check_outs("R1");
    rst = 1'b0;

    for (int i = 0; i < 600; i++) begin
      bit s, r;
      int sel;
      sel = $urandom_range(0, 9);
      s = (sel < 3) || (sel == 8);
      r = ((sel >= 3) && (sel < 6)) || (sel == 8);
      if (sel == 9) begin s = 1'b1; r = 1'b1; end
      step(s, r, "R11 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule